// File: doc/BRIEF.md
# Hash Engine Register Front-End

This block is the register-mapped control and status face of a multi-algorithm hash engine. Software programs a message length in bits as a 64-bit value split over two words, then writes a control word. The control word chooses the digest algorithm and the input byte lane order, and it arms the engine. Message words then arrive on a separate write port. Once enough words have arrived to cover the programmed length, a stand-in compression core waits a fixed latency. It then loads every digest word into a result queue in a single cycle. Software drains the queue one word per register read, starting with the last digest word.

Four sticky event bits record the following: digest words became available, a new result set was loaded, the queue was read while empty, and data arrived before the engine was armed. Each bit clears when software writes a 1 to its position in the clear register. A level interrupt follows the masked events. A soft-reset register holds the engine idle while it is set. Software uses the block by programming length and control, streaming words, taking the interrupt, and popping the digest.

Top module: `hash_regfront`

## Requirements
- R1: After the reset input is released, the event bits, the busy flag, the interrupt and the enable mask read as zero, and the queue is empty.
- R2: The length-high register (address 0x04) and the length-low register (address 0x08) read back what was written. Together they form a 64-bit bit count, with the high register as the upper half.
- R3: The control register (address 0x0C) keeps the algorithm in bits [1:0] (0 MD5, 1 SHA-1, 2 SHA-224, 3 SHA-256) and the byte order in bits [9:8]. All other bits read as zero. Writing it arms the engine and clears the running data accumulator.
- R4: While armed, each data-port word is XOR-accumulated. In the cycle that the accepted word count times 32 reaches the programmed bit length, the busy flag (status bit 8) sets. For a zero length, this happens on the control write. Exactly LATENCY cycles later, busy drops, the engine disarms, and event bits 0 and 1 set.
- R5: On completion the queue holds 4, 5, 7 or 8 words for algorithms 0 to 3. Digest word k equals the accumulator XOR {8'hD1, 2'b00, order, 2'b00, algo, 8'h00, k[7:0]}. Reads of address 0x1C pop one word each, and the first read returns the word with the highest k.
- R6: A read of address 0x1C while the queue is empty returns zero and sets event bit 2.
- R7: A data-port word arriving while the engine is not armed sets event bit 3. The word is dropped: it starts no computation and contributes to no digest.
- R8: A write to the clear register (address 0x18) clears exactly the event bits written as 1. The other bits stay set. An event that occurs in the same cycle wins over the clear.
- R9: The interrupt output is high exactly when some event bit in [3:0] of status (address 0x10) has its matching bit set in the enable register (address 0x14).
- R10: While bit 0 of the reset register (address 0x00) is 1, the queue stays empty, the event bits and busy stay zero, the engine stays disarmed, and control and data writes are ignored. Writing 0 to that bit releases the engine.
- R11: Addresses 0x50, 0x60 and 0x70 return the constants REV_ID, DESC1 and DESC2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the queue at 0x1C) |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of reg_rd |
| data_wr | input | 1 | Message word strobe |
| data_in | input | 32 | Message word |
| irq | output | 1 | Level interrupt |

## Verification
The message path is exercised with all four algorithms, each with a different byte order. The lengths are one exact multiple of 32 bits, lengths that end partway through a word, and zero. This separates an off-by-one in the word-count threshold from a wrong digest size, and shows that the zero-length case starts from the control write alone. Busy is sampled in every cycle of the latency window, so completion one cycle early or late is caught. Popping one word past the end of each digest ties the empty-read error to the real queue depth. A data word written before arming, and again after a soft reset, shows that the armed state is cleared.

// File: rtl/hash_regfront.sv
module hash_regfront #(
  parameter int          LATENCY = 6,
  parameter int          QD      = 8,
  parameter logic [31:0] REV_ID  = 32'h0002_0001,
  parameter logic [31:0] DESC1   = 32'h0000_000F,
  parameter logic [31:0] DESC2   = 32'h0000_0008
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        data_wr,
  input  logic [31:0] data_in,
  output logic        irq
);
  localparam logic [7:0] A_RST = 8'h00, A_LHI = 8'h04, A_LLO = 8'h08, A_CTL = 8'h0C;
  localparam logic [7:0] A_STA = 8'h10, A_ENA = 8'h14, A_CLR = 8'h18, A_QUE = 8'h1C;
  localparam logic [7:0] A_REV = 8'h50, A_DS1 = 8'h60, A_DS2 = 8'h70;
  localparam int QW = $clog2(QD + 1);
  localparam int IW = $clog2(QD);
  localparam int LW = $clog2(LATENCY + 1);

  logic          srst, cfg, busy;
  logic [31:0]   len_hi, len_lo, rcvd, acc;
  logic [1:0]    algo, order;
  logic [3:0]    stat, en;
  logic [LW-1:0] lcnt;
  logic [31:0]   q [QD];
  logic [QW-1:0] qcnt, ndig;
  logic [IW-1:0] top_idx;

  wire        ctl_w   = reg_wr && reg_addr == A_CTL && !srst;
  wire        pop     = reg_rd && reg_addr == A_QUE && !srst;
  wire        empty   = qcnt == '0;
  wire        accept  = data_wr && cfg && !busy && !srst;
  wire [31:0] rcvd_nx = rcvd + 32'd1;
  wire        hit     = {27'b0, rcvd_nx, 5'b0} >= {len_hi, len_lo};
  wire        zlen    = {len_hi, len_lo} == 64'd0;
  wire        done    = busy && lcnt == LW'(1);
  wire [3:0]  clr_v   = (reg_wr && reg_addr == A_CLR) ? reg_wdata[3:0] : 4'b0;
  wire [3:0]  set_v   = {data_wr && !cfg && !srst, pop && empty, done, done};

  assign top_idx = IW'(qcnt - QW'(1));
  assign irq     = |(stat & en);

  always_comb
    case (algo)
      2'd0:    ndig = QW'(4);
      2'd1:    ndig = QW'(5);
      2'd2:    ndig = QW'(7);
      default: ndig = QW'(8);
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      srst <= 1'b0; len_hi <= '0; len_lo <= '0; en <= '0;
    end else if (reg_wr) begin
      if (reg_addr == A_RST) srst   <= reg_wdata[0];
      if (reg_addr == A_LHI) len_hi <= reg_wdata;
      if (reg_addr == A_LLO) len_lo <= reg_wdata;
      if (reg_addr == A_ENA) en     <= reg_wdata[3:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg <= 1'b0; busy <= 1'b0; rcvd <= '0; acc <= '0; lcnt <= '0;
      algo <= '0; order <= '0; stat <= '0; qcnt <= '0;
      for (int k = 0; k < QD; k++) q[k] <= '0;
    end else if (srst) begin
      cfg <= 1'b0; busy <= 1'b0; rcvd <= '0; acc <= '0; lcnt <= '0;
      stat <= '0; qcnt <= '0;
    end else begin
      stat <= (stat & ~clr_v) | set_v;
      if (pop && !empty) qcnt <= qcnt - QW'(1);
      if (ctl_w) begin
        algo <= reg_wdata[1:0]; order <= reg_wdata[9:8];
        cfg <= 1'b1; rcvd <= '0; acc <= '0;
        busy <= zlen; lcnt <= LW'(LATENCY);
      end else if (accept) begin
        rcvd <= rcvd_nx; acc <= acc ^ data_in;
        if (hit) begin busy <= 1'b1; lcnt <= LW'(LATENCY); end
      end else if (done) begin
        busy <= 1'b0; cfg <= 1'b0; qcnt <= ndig;
        for (int k = 0; k < QD; k++)
          q[k] <= acc ^ {8'hD1, 2'b00, order, 2'b00, algo, 8'h00, 8'(k)};
      end else if (busy) lcnt <= lcnt - LW'(1);
    end

  always_comb
    case (reg_addr)
      A_RST:   reg_rdata = {31'b0, srst};
      A_LHI:   reg_rdata = len_hi;
      A_LLO:   reg_rdata = len_lo;
      A_CTL:   reg_rdata = {22'b0, order, 6'b0, algo};
      A_STA:   reg_rdata = {23'b0, busy, 4'b0, stat};
      A_ENA:   reg_rdata = {28'b0, en};
      A_QUE:   reg_rdata = empty ? 32'b0 : q[top_idx];
      A_REV:   reg_rdata = REV_ID;
      A_DS1:   reg_rdata = DESC1;
      A_DS2:   reg_rdata = DESC2;
      default: reg_rdata = 32'b0;
    endcase
endmodule

// File: rtl/hash_regfront_chk.sv
module hash_regfront_chk #(parameter int QW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          srst,
  input logic          cfg,
  input logic          data_wr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [7:0]    reg_addr,
  input logic [QW-1:0] qcnt,
  input logic [3:0]    stat,
  input logic          irq
);
  // R6
  empty_pop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 8'h1C && qcnt == '0 && !srst && !reg_wr) |=> stat[2]);
  // R7
  early_data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !cfg && !srst && !reg_wr) |=> stat[3]);
  // R10
  soft_reset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (qcnt == '0 && stat == 4'b0 && !cfg));
  // R5
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt <= QW'(8));
  // R4
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qcnt > $past(qcnt)) |-> (stat[0] && stat[1]));
  // R9
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == 4'b0) |-> !irq);
endmodule

bind hash_regfront hash_regfront_chk #(.QW(QW)) chk_i (
  .clk(clk), .rst_n(rst_n), .srst(srst), .cfg(cfg), .data_wr(data_wr),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .qcnt(qcnt),
  .stat(stat), .irq(irq)
);

// File: tb/hash_regfront_tb.sv
module hash_regfront_tb_top;
  localparam int L = 6;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, data_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, data_in = 0, reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];

  hash_regfront #(.LATENCY(L)) dut_i (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic dwr(logic [31:0] d);
    data_wr = 1; data_in = d;
    @(negedge clk); data_wr = 0;
  endtask

  function automatic int ndig(int al);
    return al == 0 ? 4 : al == 1 ? 5 : al == 2 ? 7 : 8;
  endfunction

  // driver: programs a message, pushes expected digest words (pop order) to the scoreboard
  task automatic run_msg(int al, int od, logic [63:0] bits);
    logic [31:0] acc = 0, v;
    int nw = int'((bits + 64'd31) / 64'd32);
    wr(8'h18, 32'hF);
    wr(8'h04, bits[63:32]);
    wr(8'h08, bits[31:0]);
    wr(8'h0C, {22'b0, 2'(od), 6'b0, 2'(al)});
    for (int i = 0; i < nw; i++) begin
      v = (32'h9E37_79B9 * (i + 1)) ^ {al[7:0], 24'h5A5A00};
      acc ^= v;
      dwr(v);
    end
    for (int k = ndig(al) - 1; k >= 0; k--)
      exp_q.push_back(acc ^ {8'hD1, 2'b00, 2'(od), 2'b00, 2'(al), 8'h00, 8'(k)});
    for (int j = 0; j < L; j++) begin
      rd(8'h10, v);
      chk("R4 busy during latency", v, 32'h100);
    end
    rd(8'h10, v);
    chk("R4 completion flags", v, 32'h3);
  endtask

  // monitor: drains the queue and compares against the scoreboard
  task automatic drain();
    logic [31:0] v;
    while (exp_q.size() > 0) begin
      rd(8'h1C, v);
      chk("R5 digest word", v, exp_q.pop_front());
    end
    rd(8'h1C, v);
    chk("R6 empty pop data", v, 32'h0);
    rd(8'h10, v);
    chk("R6 empty pop flag", v, 32'h7);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h10, v); chk("R1 status at reset", v, 32'h0);
    rd(8'h14, v); chk("R1 enable at reset", v, 32'h0);
    chk("R1 irq at reset", {31'b0, irq}, 32'h0);
    rd(8'h50, v); chk("R11 revision", v, 32'h0002_0001);
    rd(8'h60, v); chk("R11 desc1", v, 32'h0000_000F);
    rd(8'h70, v); chk("R11 desc2", v, 32'h0000_0008);
    dwr(32'hDEAD_BEEF);
    rd(8'h10, v); chk("R7 early data flag, no busy", v, 32'h8);
    chk("R9 masked event gives no irq", {31'b0, irq}, 32'h0);
    rd(8'h1C, v); chk("R7 dropped data leaves queue empty", v, 32'h0);
    rd(8'h10, v); chk("R6 empty read flag", v, 32'hC);
    wr(8'h14, 32'h8);
    chk("R9 enabled event raises irq", {31'b0, irq}, 32'h1);
    wr(8'h18, 32'h4);
    rd(8'h10, v); chk("R8 selective clear", v, 32'h8);
    wr(8'h18, 32'h8);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(8'h04, 32'h1234_5678); wr(8'h08, 32'h9ABC_DEF0);
    rd(8'h04, v); chk("R2 length high", v, 32'h1234_5678);
    rd(8'h08, v); chk("R2 length low", v, 32'h9ABC_DEF0);
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, v); chk("R3 control fields", v, 32'h0000_0302);
    wr(8'h00, 32'h1); wr(8'h00, 32'h0);
    wr(8'h14, 32'h2);
    run_msg(3, 0, 64'd256);
    chk("R9 new-results irq", {31'b0, irq}, 32'h1);
    drain();
    run_msg(0, 1, 64'd100);
    drain();
    run_msg(1, 2, 64'd0);
    drain();
    run_msg(2, 3, 64'd33);
    drain();
    dwr(32'h1111_2222);
    rd(8'h10, v); chk("R7 data after completion disarmed", v, 32'hF);
    wr(8'h18, 32'hF);
    wr(8'h04, 0); wr(8'h08, 0); wr(8'h0C, 32'h1);
    repeat (L + 1) @(negedge clk);
    rd(8'h10, v); chk("R4 zero length completes", v, 32'h3);
    wr(8'h00, 32'h1);
    rd(8'h00, v); chk("R10 reset bit reads back", v, 32'h1);
    rd(8'h10, v); chk("R10 status cleared in reset", v, 32'h0);
    rd(8'h1C, v); chk("R10 queue emptied", v, 32'h0);
    wr(8'h0C, 32'h3);
    dwr(32'h5);
    rd(8'h10, v); chk("R10 writes ignored in reset", v, 32'h0);
    wr(8'h00, 32'h0);
    dwr(32'h6);
    rd(8'h10, v); chk("R10 disarmed after release", v, 32'h8);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule